// File: doc/BRIEF.md
# Output Port Pulse and Reset Controller

This block holds the 8-bit output port of a peripheral controller. The port's bits drive the CPU reset (bit 0, low asserts reset), the A20 address gate (bit 1, low forces A20 to 0), the auxiliary device's data and clock (bits 2 and 3), the two interrupt lines (bit 4 for the keyboard, bit 5 for the auxiliary device), and the keyboard's clock and data (bits 6 and 7). The command processor sends it one request at a time. A request is either a whole-port write or a pulse opcode.

A pulse opcode lies in the range 0xF0 to 0xFF. Each clear bit in its low nibble picks the matching port bit, from 3 down to 0. The picked bits go low for a fixed time and then come back to the values they held before. The length of that time is worked out from the clock frequency and a width in nanoseconds. The default is 6000 ns. Opcode 0xFE pulses only bit 0, which gives a timed CPU reset.

While a pulse runs, the block raises a busy flag. A request that arrives during the pulse is held in a single slot and carried out after the pulse ends.

Top module: `outport_pulse_ctl`

## Requirements
- R1: After reset the port reads RST_VAL (default 0xFF) and busy is low. With that default, the CPU reset output is low and the A20 output is high.
- R2: A write request (req_kind = 0) accepted while idle replaces all eight port bits. The new value appears on port_o in the cycle after acceptance.
- R3: A pulse request (req_kind = 1) with opcode 0xF0 to 0xFF drives port bit i low, for i from 0 to 3, exactly when bit i of the opcode is 0. The bits go low in the cycle after acceptance.
- R4: The selected bits stay low for exactly PULSE_CYCLES clock cycles. PULSE_CYCLES is CLK_HZ × PULSE_NS / 10^9, rounded up, with a minimum of 1. After those cycles the port shows its value from before the pulse again.
- R5: During a pulse, bits 7 to 4 and any low-nibble bits that were not selected do not change.
- R6: cpu_reset_o is high exactly when port bit 0 is low, whether a write or a pulse made it low. a20_o equals port bit 1.
- R7: busy_o is high in every cycle in which a pulse is running or a request is being held.
- R8: A request that arrives during a pulse is held. It takes effect at the second clock edge after the pulse ends, so a held write appears on port_o one cycle after the port has been restored.
- R9: A request that arrives while another request is already being held is dropped.
- R10: A pulse request whose upper nibble is not 0xF, or whose low nibble is 0xF, changes nothing on port_o and does not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_kind | input | 1 | 0 = whole-port write, 1 = pulse opcode |
| req_byte | input | 8 | Write data or pulse opcode |
| port_o | output | 8 | Current port value, also used for read-back |
| busy_o | output | 1 | Pulse running or request held |
| cpu_reset_o | output | 1 | CPU reset, active high, from port bit 0 |
| a20_o | output | 1 | A20 enable, from port bit 1 |

## Verification
The assertions check the following on every cycle:
- the port value right after reset is released;
- a write lands on the port in the next cycle;
- the selected bits are low once a pulse has started;
- the upper nibble does not move while a pulse runs;
- the pulse lasts exactly PULSE_CYCLES cycles, measured by a counter in the checker;
- busy is high whenever a pulse is running;
- ignored opcodes have no effect.

Some behaviours only the bench's scenarios can show. These are restoring the exact earlier value after each mask pattern, the timing at which a held request takes effect, and dropping a second request while one is already held.

// File: rtl/outport_pkg.sv
package outport_pkg;

  typedef enum logic {
    REQ_WRITE = 1'b0,
    REQ_PULSE = 1'b1
  } req_kind_e;

  // Port bits selected by a pulse opcode: inverted low nibble, only in 0xF0..0xFF
  function automatic logic [3:0] pulse_sel(input logic [7:0] op);
    return (op[7:4] == 4'hF) ? ~op[3:0] : 4'h0;
  endfunction

  // Pulse width in clock cycles, rounded up, minimum one
  function automatic int unsigned pulse_cycles(input longint unsigned clk_hz,
                                               input longint unsigned width_ns);
    longint unsigned c;
    c = (clk_hz * width_ns + 64'd999_999_999) / 64'd1_000_000_000;
    return (c == 0) ? 1 : int'(c);
  endfunction

endpackage

// File: rtl/outport_req_hold.sv
module outport_req_hold
  import outport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  req_kind_e  req_kind,
  input  logic [7:0] req_byte,
  input  logic       active_i,
  output logic       launch_o,
  output req_kind_e  kind_o,
  output logic [7:0] byte_o,
  output logic       pend_o
);

  logic       pend_q;
  req_kind_e  pend_kind_q;
  logic [7:0] pend_byte_q;

  assign launch_o = !active_i && (pend_q || req_valid);
  assign kind_o   = pend_q ? pend_kind_q : req_kind;
  assign byte_o   = pend_q ? pend_byte_q : req_byte;
  assign pend_o   = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_kind_q <= REQ_WRITE;
      pend_byte_q <= 8'h00;
    end else if (launch_o && pend_q) begin
      // the held request is launched; a fresh request takes the slot
      pend_q <= req_valid;
      if (req_valid) begin
        pend_kind_q <= req_kind;
        pend_byte_q <= req_byte;
      end
    end else if (active_i && req_valid && !pend_q) begin
      pend_q      <= 1'b1;
      pend_kind_q <= req_kind;
      pend_byte_q <= req_byte;
    end
  end

endmodule

// File: rtl/outport_pulse_timer.sv
module outport_pulse_timer #(
  parameter int unsigned PULSE_CYCLES = 750
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [3:0] mask_i,
  output logic       active_o,
  output logic [3:0] mask_o
);

  localparam int unsigned CW = (PULSE_CYCLES < 2) ? 1 : $clog2(PULSE_CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      mask_o   <= 4'h0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      mask_o   <= mask_i;
      cnt_q    <= LOAD;
    end else if (active_o) begin
      if (cnt_q == '0) begin
        active_o <= 1'b0;
        mask_o   <= 4'h0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/outport_port_reg.sv
module outport_port_reg #(
  parameter logic [7:0] RST_VAL = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       pulse_on_i,
  input  logic [3:0] pulse_mask_i,
  output logic [7:0] port_o
);

  logic [7:0] base_q;
  logic [3:0] low_force;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base_q <= RST_VAL;
    else if (wr_i) base_q <= wdata_i;
  end

  assign low_force = pulse_on_i ? pulse_mask_i : 4'h0;
  assign port_o    = base_q & ~{4'h0, low_force};

endmodule

// File: rtl/outport_pulse_ctl.sv
module outport_pulse_ctl
  import outport_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 125_000_000,
  parameter int unsigned PULSE_NS = 6000,
  parameter logic [7:0]  RST_VAL  = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_kind,
  input  logic [7:0] req_byte,
  output logic [7:0] port_o,
  output logic       busy_o,
  output logic       cpu_reset_o,
  output logic       a20_o
);

  localparam int unsigned PULSE_CYCLES = pulse_cycles(64'(CLK_HZ), 64'(PULSE_NS));

  // named internal events, observed by the bound checker
  logic       launch_w;
  req_kind_e  launch_kind_w;
  logic [7:0] launch_byte_w;
  logic       pend_w;
  logic       launch_wr_w;
  logic       launch_pulse_w;
  logic       start_w;
  logic [3:0] sel_w;
  logic       active_w;
  logic [3:0] mask_w;

  outport_req_hold hold_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind_e'(req_kind)),
    .req_byte  (req_byte),
    .active_i  (active_w),
    .launch_o  (launch_w),
    .kind_o    (launch_kind_w),
    .byte_o    (launch_byte_w),
    .pend_o    (pend_w)
  );

  assign sel_w          = pulse_sel(launch_byte_w);
  assign launch_wr_w    = launch_w && (launch_kind_w == REQ_WRITE);
  assign launch_pulse_w = launch_w && (launch_kind_w == REQ_PULSE);
  assign start_w        = launch_pulse_w && (sel_w != 4'h0);

  outport_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_w),
    .mask_i   (sel_w),
    .active_o (active_w),
    .mask_o   (mask_w)
  );

  outport_port_reg #(.RST_VAL(RST_VAL)) port_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (launch_wr_w),
    .wdata_i      (launch_byte_w),
    .pulse_on_i   (active_w),
    .pulse_mask_i (mask_w),
    .port_o       (port_o)
  );

  assign busy_o      = active_w || pend_w;
  assign cpu_reset_o = ~port_o[0];
  assign a20_o       = port_o[1];

endmodule

// File: rtl/outport_pulse_chk.sv
module outport_pulse_chk
  import outport_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 125_000_000,
  parameter int unsigned PULSE_NS = 6000,
  parameter logic [7:0]  RST_VAL  = 8'hFF
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] port_o,
  input logic       busy_o,
  input logic       active_w,
  input logic [3:0] mask_w,
  input logic       start_w,
  input logic       launch_wr_w,
  input logic       launch_pulse_w,
  input logic [7:0] launch_byte_w
);

  localparam int unsigned PULSE_CYCLES = pulse_cycles(64'(CLK_HZ), 64'(PULSE_NS));

  logic [31:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_cnt <= '0;
    else if (active_w) run_cnt <= run_cnt + 1;
    else               run_cnt <= '0;
  end

  // R1
  reset_value_chk: assert property (@(posedge clk) $rose(rst_n) |-> port_o == RST_VAL);

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_wr_w |=> port_o == $past(launch_byte_w));

  // R3
  pulse_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (port_o[3:0] & mask_w) == 4'h0 && mask_w != 4'h0);

  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_w) |-> run_cnt == PULSE_CYCLES);

  // R5
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_w |=> $stable(port_o[7:4]));

  // R7
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_w |-> busy_o);

  // R10
  ignored_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_pulse_w && (launch_byte_w[7:4] != 4'hF || launch_byte_w[3:0] == 4'hF)
    |=> !active_w && $stable(port_o));

endmodule

bind outport_pulse_ctl outport_pulse_chk #(
  .CLK_HZ(CLK_HZ), .PULSE_NS(PULSE_NS), .RST_VAL(RST_VAL)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .port_o         (port_o),
  .busy_o         (busy_o),
  .active_w       (active_w),
  .mask_w         (mask_w),
  .start_w        (start_w),
  .launch_wr_w    (launch_wr_w),
  .launch_pulse_w (launch_pulse_w),
  .launch_byte_w  (launch_byte_w)
);

// File: tb/outport_pulse_ctl_tb_top.sv
`timescale 1ns/1ps
module outport_pulse_ctl_tb_top;

  // 125 MHz clock, 40 ns pulse -> 5 cycles
  localparam int EXP_P = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_kind = 1'b0;
  logic [7:0] req_byte = 8'h00;
  logic [7:0] port_o;
  logic       busy_o, cpu_reset_o, a20_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  outport_pulse_ctl #(.CLK_HZ(125_000_000), .PULSE_NS(40), .RST_VAL(8'hFF)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_byte(req_byte), .port_o(port_o), .busy_o(busy_o),
    .cpu_reset_o(cpu_reset_o), .a20_o(a20_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // drive one request from a negedge; returns at the negedge after the accepting edge
  task automatic send(input bit kind, input logic [7:0] b);
    req_valid = 1'b1; req_kind = kind; req_byte = b;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(port_o == 8'hFF, "R1 port", port_o, 8'hFF);
    check(busy_o == 1'b0, "R1 busy", busy_o, 0);
    check(cpu_reset_o == 1'b0 && a20_o == 1'b1, "R1 reset/a20", {cpu_reset_o, a20_o}, 2'b01);
  endtask

  task automatic t_write();
    send(1'b0, 8'h5A);
    check(port_o == 8'h5A, "R2 write", port_o, 8'h5A);
    check(cpu_reset_o == 1'b1, "R6 reset via write", cpu_reset_o, 1);
    check(a20_o == 1'b1, "R6 a20 high", a20_o, 1);
    send(1'b0, 8'hFD);
    check(port_o == 8'hFD, "R2 write 2", port_o, 8'hFD);
    check(a20_o == 1'b0 && cpu_reset_o == 1'b0, "R6 a20 low", {cpu_reset_o, a20_o}, 0);
  endtask

  task automatic t_pulse(input logic [7:0] base, input logic [7:0] op);
    logic [7:0] low;
    low = base & ~{4'h0, ~op[3:0]};
    send(1'b0, base);
    send(1'b1, op);
    for (int k = 0; k < EXP_P; k++) begin
      check(port_o == low, "R3/R4 low phase", port_o, low);
      check(port_o[7:4] == base[7:4], "R5 upper hold", port_o[7:4], base[7:4]);
      check(busy_o == 1'b1, "R7 busy in pulse", busy_o, 1);
      if (op == 8'hFE)
        check(cpu_reset_o == base[0], "R6 reset via pulse", cpu_reset_o, base[0]);
      @(negedge clk);
    end
    check(port_o == base, "R4 restored", port_o, base);
    check(busy_o == 1'b0, "R7 busy clear", busy_o, 0);
  endtask

  task automatic t_ignored();
    send(1'b0, 8'h3C);
    send(1'b1, 8'hD1);
    check(port_o == 8'h3C && busy_o == 1'b0, "R10 non-F opcode", port_o, 8'h3C);
    send(1'b1, 8'hFF);
    check(port_o == 8'h3C && busy_o == 1'b0, "R10 empty mask", port_o, 8'h3C);
    @(negedge clk);
    check(port_o == 8'h3C, "R10 no late effect", port_o, 8'h3C);
  endtask

  task automatic t_held();
    send(1'b0, 8'hFF);
    send(1'b1, 8'hFC);
    check(port_o == 8'hFC, "R3 pulse bits 1:0", port_o, 8'hFC);
    send(1'b0, 8'h81);
    for (int k = 1; k < EXP_P; k++) begin
      check(port_o == 8'hFC, "R8 held write not applied", port_o, 8'hFC);
      @(negedge clk);
    end
    check(port_o == 8'hFF && busy_o == 1'b1, "R8 restored, still busy", port_o, 8'hFF);
    @(negedge clk);
    check(port_o == 8'h81, "R8 held write applied", port_o, 8'h81);
    check(busy_o == 1'b0, "R7 busy after held", busy_o, 0);
  endtask

  task automatic t_drop();
    send(1'b0, 8'hFF);
    send(1'b1, 8'hF7);
    send(1'b0, 8'h5A);
    send(1'b0, 8'h33);
    repeat (EXP_P + 2) @(negedge clk);
    check(port_o == 8'h5A, "R9 second dropped", port_o, 8'h5A);
    check(busy_o == 1'b0, "R9 idle", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_pulse(8'hFF, 8'hFE);
    t_pulse(8'hA5, 8'hF0);
    t_pulse(8'h3C, 8'hFA);
    t_ignored();
    t_held();
    t_drop();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule